// File: doc/BRIEF.md
# Receive Destination-Address Filter

This block sits beside an Ethernet receive path and judges each incoming frame by its destination address. The receiver presents the six address bytes one per clock, the first one on the wire flagged as the start of a frame. While the bytes stream in, the block runs the Ethernet CRC-32 over them and captures the whole address. When the last byte arrives it combines the results. These are the address class (unicast, multicast or broadcast), an exact match against a programmed station address, and a lookup into a 64-entry hash table indexed by six bits of the CRC. Per-class enable bits select which results count. The accept/reject verdict appears one clock later.

A small write port loads the station address, the two halves of the hash table and the control bits. When wake reporting is enabled, every filter match also sets sticky wake flags that record which classes matched. Software clears those flags by writing ones to a clear register. Everything after the sixth address byte, including the payload and FCS, is ignored until the next frame start.

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous reset, `res_valid`, `res_accept`, `res_reject` and `wake_flags` are all zero, the control bits are zero and capture is idle.
- R2: The hash index is bits 28 down to 23 of a CRC computed over the six address bytes, first byte first. The CRC starts at 0xFFFFFFFF, uses polynomial 0x04C11DB7, feeds each byte least-significant bit first, and is not inverted. The table is {high word at `cfg_addr` 4, low word at `cfg_addr` 3}, so indices 32 to 63 select bit (index-32) of the high word.
- R3: An address whose six bytes are all 0xFF is broadcast. Otherwise it is multicast when bit 0 of the first received byte is 1, and unicast when that bit is 0.
- R4: Control register (`cfg_addr` 5) bit 0 accepts every unicast address, bit 1 accepts broadcast, and bit 2 accepts every multicast address. A broadcast address is not accepted by bit 2 alone.
- R5: Control bit 3 applies the hash table to unicast addresses and bit 4 applies it to multicast addresses. The address passes when the selected table bit is 1.
- R6: Control bit 5 accepts an address equal to the station address. `cfg_addr` 0 holds bytes 5 (bits 15:8) and 4 (bits 7:0), `cfg_addr` 1 holds bytes 3 and 2, and `cfg_addr` 2 holds bytes 1 and 0. Byte 0 is the first byte received.
- R7: Control bit 6 (pass-all) accepts every frame, whatever the other filter results.
- R8: A verdict is presented for exactly one cycle, the cycle after the sixth address byte is taken. `res_accept` or `res_reject` is then high, never both. Both are low when `res_valid` is low. Control values in force on the sixth-byte cycle govern the verdict.
- R9: A byte with `rx_sof` high always restarts capture as byte 0. Bytes with `rx_valid` high but `rx_sof` low are ignored after the sixth byte, and before any frame start, and produce no verdict.
- R10: When control bit 7 (wake enable) is 1 and at least one filter matches, the verdict edge ORs the match bits into `wake_flags`. Bit 0 is unicast-all, 1 broadcast, 2 multicast-all, 3 unicast hash, 4 multicast hash, 5 perfect match and 6 any filter match. The flags are sticky.
- R11: A write to `cfg_addr` 6 clears each `wake_flags` bit whose `cfg_wdata` bit is 1. If a flag is set and cleared on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select (0..6) |
| cfg_wdata | input | 32 | Configuration write data |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first destination-address byte of a frame |
| rx_byte | input | 8 | Receive byte |
| res_valid | output | 1 | Verdict strobe, one cycle |
| res_accept | output | 1 | Frame accepted (with `res_valid`) |
| res_reject | output | 1 | Frame rejected (with `res_valid`) |
| wake_flags | output | 7 | Sticky wake flags by matching filter class |

## Verification
The bench builds the block with its default parameters: a six-byte address, a six-bit hash index over a 64-bit table, and the hash index taken from CRC bit 23 upward. With the 64-bit table split into two words, the bench searches addresses until it finds hash indices on both sides of 32, which exercises the low-word and high-word lookups. The station address spans all three halfword registers, so every halfword and byte ordering of the perfect match can be reached. Randomised frames with random control words and tables, interleaved with aborted captures, trailing bytes and coincident wake clears, are compared cycle by cycle against a behavioural model.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

    localparam int          ADDR_BYTES = 6;
    localparam int          HASH_W     = 6;
    localparam int          HASH_LSB   = 23;
    localparam int          CRC_W      = 32;
    localparam logic [31:0] CRC_POLY   = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT   = 32'hFFFF_FFFF;

    // Configuration register select values
    typedef enum logic [2:0] {
        REG_STA_HI   = 3'd0,
        REG_STA_MID  = 3'd1,
        REG_STA_LO   = 3'd2,
        REG_HASH_LO  = 3'd3,
        REG_HASH_HI  = 3'd4,
        REG_CTRL     = 3'd5,
        REG_WAKE_CLR = 3'd6
    } rxaf_reg_e;

    // Control word, bit 7 down to bit 0
    typedef struct packed {
        logic wake_en;
        logic pass_all;
        logic perfect_en;
        logic mc_hash_en;
        logic uc_hash_en;
        logic mc_all_en;
        logic bc_en;
        logic uc_all_en;
    } rxaf_ctrl_t;

    // Filter match vector, bit 6 down to bit 0
    typedef struct packed {
        logic any;
        logic perfect;
        logic mc_hash;
        logic uc_hash;
        logic mc_all;
        logic bc;
        logic uc_all;
    } rxaf_hits_t;

    localparam int HITS_W = $bits(rxaf_hits_t);
    localparam int CTRL_W = $bits(rxaf_ctrl_t);

    typedef enum logic [1:0] {
        CLS_UNI   = 2'd0,
        CLS_MULTI = 2'd1,
        CLS_BROAD = 2'd2
    } rxaf_class_e;

    // One byte of the CRC, bits taken least-significant first
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                  input logic [7:0]       d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

endpackage

// File: rtl/rxaf_cfg.sv
module rxaf_cfg
    import rxaf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int IDX_W   = HASH_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [2:0]             addr,
    input  logic [31:0]            wdata,
    input  logic                   set_valid,
    input  rxaf_hits_t             set_hits,
    output logic [N_BYTES*8-1:0]   station,
    output logic [(1<<IDX_W)-1:0]  table_bits,
    output rxaf_ctrl_t             ctrl,
    output logic [HITS_W-1:0]      wake
);
    localparam int TBL_BITS = 1 << IDX_W;
    localparam int STA_BITS = N_BYTES * 8;

    rxaf_reg_e          sel;
    logic [HITS_W-1:0]  clr_mask;
    logic [HITS_W-1:0]  set_mask;

    always_comb begin
        sel      = rxaf_reg_e'(addr);
        clr_mask = (we && sel == REG_WAKE_CLR) ? wdata[HITS_W-1:0] : '0;
        set_mask = (set_valid && ctrl.wake_en && set_hits.any) ? set_hits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            station    <= '0;
            table_bits <= '0;
            ctrl       <= '0;
        end else if (we) begin
            unique case (sel)
                REG_STA_HI:  station[STA_BITS-1 -: 16]   <= wdata[15:0];
                REG_STA_MID: station[STA_BITS-17 -: 16]  <= wdata[15:0];
                REG_STA_LO:  station[15:0]               <= wdata[15:0];
                REG_HASH_LO: table_bits[31:0]            <= wdata;
                REG_HASH_HI: table_bits[TBL_BITS-1 -: 32] <= wdata;
                REG_CTRL:    ctrl                        <= rxaf_ctrl_t'(wdata[CTRL_W-1:0]);
                default: ;
            endcase
        end
    end

    // Sticky wake flags: set wins over a coincident clear
    always_ff @(posedge clk) begin
        if (rst) wake <= '0;
        else     wake <= (wake & ~clr_mask) | set_mask;
    end

endmodule

// File: rtl/rxaf_capture.sv
module rxaf_capture
    import rxaf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int IDX_W   = HASH_W,
    parameter int IDX_LSB = HASH_LSB
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic [7:0]            rx_byte,
    output logic                  done,
    output logic [N_BYTES*8-1:0]  addr_full,
    output logic [IDX_W-1:0]      hash_idx
);
    localparam int CNT_W = $clog2(N_BYTES + 1);

    logic [CNT_W-1:0]     cnt_q;
    logic                 active_q;
    logic [CRC_W-1:0]     crc_q;
    logic [N_BYTES*8-1:0] addr_q;

    logic [CNT_W-1:0]     idx;
    logic                 take;
    logic [CRC_W-1:0]     crc_nx;

    always_comb begin
        idx       = rx_sof ? '0 : cnt_q;
        take      = rx_valid && (rx_sof || active_q);
        crc_nx    = crc_byte(rx_sof ? CRC_INIT : crc_q, rx_byte);
        addr_full = addr_q;
        addr_full[idx*8 +: 8] = rx_byte;
        done      = take && (idx == CNT_W'(N_BYTES - 1));
        hash_idx  = crc_nx[IDX_LSB +: IDX_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            active_q <= 1'b0;
            crc_q    <= CRC_INIT;
            addr_q   <= '0;
        end else if (take) begin
            cnt_q    <= idx + 1'b1;
            active_q <= !done;
            crc_q    <= crc_nx;
            addr_q   <= addr_full;
        end
    end

endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
    import rxaf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int IDX_W   = HASH_W
) (
    input  logic [N_BYTES*8-1:0]  addr,
    input  logic [IDX_W-1:0]      hash_idx,
    input  logic [N_BYTES*8-1:0]  station,
    input  logic [(1<<IDX_W)-1:0] table_bits,
    input  rxaf_ctrl_t            ctrl,
    output rxaf_hits_t            hits,
    output logic                  accept
);
    logic [N_BYTES-1:0] byte_eq;
    rxaf_class_e        cls;
    logic               hash_hit;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_cmp
        assign byte_eq[g] = (addr[g*8 +: 8] == station[g*8 +: 8]);
    end

    always_comb begin
        if (&addr)        cls = CLS_BROAD;
        else if (addr[0]) cls = CLS_MULTI;
        else              cls = CLS_UNI;

        hash_hit = table_bits[hash_idx];

        hits.uc_all  = ctrl.uc_all_en  && cls == CLS_UNI;
        hits.bc      = ctrl.bc_en      && cls == CLS_BROAD;
        hits.mc_all  = ctrl.mc_all_en  && cls == CLS_MULTI;
        hits.uc_hash = ctrl.uc_hash_en && cls == CLS_UNI   && hash_hit;
        hits.mc_hash = ctrl.mc_hash_en && cls == CLS_MULTI && hash_hit;
        hits.perfect = ctrl.perfect_en && (&byte_eq);
        hits.any     = hits.uc_all | hits.bc | hits.mc_all |
                       hits.uc_hash | hits.mc_hash | hits.perfect;
        accept       = ctrl.pass_all || hits.any;
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
#(
    parameter int N_BYTES = ADDR_BYTES,
    parameter int IDX_W   = HASH_W,
    parameter int IDX_LSB = HASH_LSB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_byte,
    output logic              res_valid,
    output logic              res_accept,
    output logic              res_reject,
    output logic [HITS_W-1:0] wake_flags
);
    localparam int A_BITS   = N_BYTES * 8;
    localparam int TBL_BITS = 1 << IDX_W;

    logic                done;
    logic [A_BITS-1:0]   addr_full;
    logic [IDX_W-1:0]    hash_idx;
    logic [A_BITS-1:0]   station;
    logic [TBL_BITS-1:0] table_bits;
    rxaf_ctrl_t          ctrl;
    rxaf_hits_t          hits;
    logic                accept_c;
    logic                valid_q;
    logic                accept_q;

    rxaf_capture #(.N_BYTES(N_BYTES), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_byte   (rx_byte),
        .done      (done),
        .addr_full (addr_full),
        .hash_idx  (hash_idx)
    );

    rxaf_decide #(.N_BYTES(N_BYTES), .IDX_W(IDX_W)) u_dec (
        .addr       (addr_full),
        .hash_idx   (hash_idx),
        .station    (station),
        .table_bits (table_bits),
        .ctrl       (ctrl),
        .hits       (hits),
        .accept     (accept_c)
    );

    rxaf_cfg #(.N_BYTES(N_BYTES), .IDX_W(IDX_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .we         (cfg_we),
        .addr       (cfg_addr),
        .wdata      (cfg_wdata),
        .set_valid  (done),
        .set_hits   (hits),
        .station    (station),
        .table_bits (table_bits),
        .ctrl       (ctrl),
        .wake       (wake_flags)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q  <= 1'b0;
            accept_q <= 1'b0;
        end else begin
            valid_q  <= done;
            accept_q <= done && accept_c;
        end
    end

    assign res_valid  = valid_q;
    assign res_accept = valid_q &&  accept_q;
    assign res_reject = valid_q && !accept_q;

endmodule

// File: rtl/rxaf_checker.sv
module rxaf_checker (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic [2:0] cfg_addr,
    input logic       rx_valid,
    input logic       pass_all,
    input logic       res_valid,
    input logic       res_accept,
    input logic       res_reject,
    input logic [6:0] wake_flags
);
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R8

    AST_RESULT_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(rx_valid)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !(res_accept || res_reject)); // R8

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $countones({res_accept, res_reject}) == 1); // R8

    AST_PASS_ALL_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(pass_all)) |-> res_accept); // R7

    AST_WAKE_SET_ON_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (|(wake_flags & ~$past(wake_flags))) |-> res_valid); // R10

    AST_WAKE_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (|($past(wake_flags) & ~wake_flags)) |-> $past(cfg_we && cfg_addr == 3'd6)); // R11

endmodule

bind rx_addr_filter rxaf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .rx_valid   (rx_valid),
    .pass_all   (ctrl.pass_all),
    .res_valid  (res_valid),
    .res_accept (res_accept),
    .res_reject (res_reject),
    .wake_flags (wake_flags)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        res_valid, res_accept, res_reject;
    logic [6:0]  wake_flags;

    rx_addr_filter dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_byte(rx_byte), .res_valid(res_valid), .res_accept(res_accept),
        .res_reject(res_reject), .wake_flags(wake_flags)
    );

    always #2 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit finished = 0;

    // ---------------- behavioural reference model ----------------
    logic [7:0]  m_ctrl;
    logic [47:0] m_sta;
    logic [63:0] m_tbl;
    logic [6:0]  m_wake;
    logic [47:0] m_a;
    bit          m_valid, m_acc, m_act;
    int          m_cnt;
    string       m_tag;

    function automatic logic [31:0] crc_of(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < 48; i++) begin
            logic fb = c[31] ^ a[i];
            c = c << 1;
            if (fb) c = c ^ 32'h04C1_1DB7;
        end
        return c;
    endfunction

    function automatic int hidx(input logic [47:0] a);
        logic [31:0] c = crc_of(a);
        return int'(c[28:23]);
    endfunction

    function automatic logic [6:0] m_hits(input logic [47:0] a);
        logic [6:0] h;
        bit bc = (a == 48'hFFFF_FFFF_FFFF);
        bit mc = a[0] && !bc;
        bit uc = !a[0];
        bit hb = m_tbl[hidx(a)];
        h[0] = m_ctrl[0] && uc;
        h[1] = m_ctrl[1] && bc;
        h[2] = m_ctrl[2] && mc;
        h[3] = m_ctrl[3] && uc && hb;
        h[4] = m_ctrl[4] && mc && hb;
        h[5] = m_ctrl[5] && (a == m_sta);
        h[6] = |h[5:0];
        return h;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = '0; m_sta = '0; m_tbl = '0; m_wake = '0;
            m_valid = 0; m_acc = 0; m_act = 0; m_cnt = 0; m_tag = "R1";
        end else begin
            logic [6:0] setw;
            logic [6:0] clr;
            setw = '0;
            m_valid = 0;
            m_acc = 0;
            if (rx_valid && (rx_sof || m_act)) begin
                int ix;
                ix = rx_sof ? 0 : m_cnt;
                m_a[8*ix +: 8] = rx_byte;
                m_cnt = ix + 1;
                if (ix == 5) begin
                    logic [6:0] h;
                    h = m_hits(m_a);
                    m_valid = 1;
                    m_acc = m_ctrl[6] || h[6];
                    m_act = 0;
                    if (m_ctrl[6])      m_tag = "R7";
                    else if (h[5])      m_tag = "R6";
                    else if (|h[4:3])   m_tag = "R5";
                    else                m_tag = "R4";
                    if (m_ctrl[7] && h[6]) setw = h;
                end else begin
                    m_act = 1;
                end
            end
            clr = (cfg_we && cfg_addr == 3'd6) ? cfg_wdata[6:0] : '0;
            m_wake = (m_wake & ~clr) | setw;
            if (cfg_we) begin
                case (cfg_addr)
                    3'd0: m_sta[47:32] = cfg_wdata[15:0];
                    3'd1: m_sta[31:16] = cfg_wdata[15:0];
                    3'd2: m_sta[15:0]  = cfg_wdata[15:0];
                    3'd3: m_tbl[31:0]  = cfg_wdata;
                    3'd4: m_tbl[63:32] = cfg_wdata;
                    3'd5: m_ctrl       = cfg_wdata[7:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R8", "res_valid", 32'(res_valid), 32'(m_valid));
            chk(m_tag, "res_accept", 32'(res_accept), 32'(m_valid && m_acc));
            chk("R8", "res_reject", 32'(res_reject), 32'(m_valid && !m_acc));
            chk("R10", "wake_flags", 32'(wake_flags), 32'(m_wake));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [47:0] a, input logic [6:0] clr);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_byte  = a[8*i +: 8];
            if (i == 5 && clr != 0) begin
                cfg_we = 1'b1; cfg_addr = 3'd6; cfg_wdata = 32'(clr);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic expect_verdict(input string tag, input bit acc);
        chk(tag, "verdict valid", 32'(res_valid), 32'd1);
        chk(tag, "verdict accept", 32'(res_accept), 32'(acc));
    endtask

    task automatic set_station(input logic [47:0] s);
        wr(3'd0, 32'(s[47:32]));
        wr(3'd1, 32'(s[31:16]));
        wr(3'd2, 32'(s[15:0]));
    endtask

    localparam logic [47:0] UNI   = 48'h5544_3322_1100;
    localparam logic [47:0] MULTI = 48'h6655_4433_2201;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] ulo, uhi, mhi;
        bit fl, fh, fm;
        fl = 0; fh = 0; fm = 0; ulo = '0; uhi = '0; mhi = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset valid", 32'(res_valid), 32'd0);
        chk("R1", "reset wake", 32'(wake_flags), 32'd0);

        // R4: nothing enabled rejects; per-class enables
        send(UNI, '0);   expect_verdict("R4", 0);
        wr(3'd5, 32'h01);
        send(UNI, '0);   expect_verdict("R4", 1);
        send(MULTI, '0); expect_verdict("R4", 0);
        wr(3'd5, 32'h04);
        send(MULTI, '0); expect_verdict("R4", 1);
        send(BCAST, '0); expect_verdict("R3", 0);  // broadcast is not multicast
        wr(3'd5, 32'h02);
        send(BCAST, '0); expect_verdict("R4", 1);
        send(MULTI, '0); expect_verdict("R3", 0);

        // R6: perfect match with station halfwords
        set_station(48'h0211_2233_4455);
        wr(3'd5, 32'h20);
        send(48'h0211_2233_4455, '0); expect_verdict("R6", 1);
        send(48'h0311_2233_4455, '0); expect_verdict("R6", 0);
        send(48'h0211_2233_4454, '0); expect_verdict("R6", 0);

        // R2/R5: hash indices in both table halves
        for (int k = 0; k < 256; k++) begin
            logic [47:0] a;
            a = {8'(k), 40'hAA_BBCC_DD02};
            if (!fl && hidx(a) < 32)  begin ulo = a; fl = 1; end
            if (!fh && hidx(a) >= 32) begin uhi = a; fh = 1; end
            a = {8'(k), 40'hAA_BBCC_DD03};
            if (!fm && hidx(a) >= 32) begin mhi = a; fm = 1; end
        end
        wr(3'd5, 32'h08);
        wr(3'd3, 32'h1 << hidx(ulo)); wr(3'd4, 32'h0);
        send(ulo, '0); expect_verdict("R2", 1);
        wr(3'd3, ~(32'h1 << hidx(ulo))); wr(3'd4, 32'hFFFF_FFFF);
        send(ulo, '0); expect_verdict("R2", 0);
        wr(3'd3, 32'h0); wr(3'd4, 32'h1 << (hidx(uhi) - 32));
        send(uhi, '0); expect_verdict("R2", 1);
        send(mhi, '0); expect_verdict("R5", 0);   // unicast hash only
        wr(3'd5, 32'h10);
        wr(3'd4, 32'h1 << (hidx(mhi) - 32));
        send(mhi, '0); expect_verdict("R5", 1);

        // R7: pass-all
        wr(3'd5, 32'h40); wr(3'd3, 0); wr(3'd4, 0);
        send(UNI, '0);   expect_verdict("R7", 1);
        send(MULTI, '0); expect_verdict("R7", 1);

        // R9: restart on sof, trailing bytes ignored
        wr(3'd5, 32'h01);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_valid = 1; rx_sof = (i == 0); rx_byte = MULTI[8*i +: 8];
        end
        send(UNI, '0); expect_verdict("R9", 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); rx_valid = 1; rx_sof = 0; rx_byte = 8'hFF;
            chk("R9", "no verdict", 32'(res_valid), 32'd0);
        end
        @(negedge clk); rx_valid = 0;
        chk("R9", "no verdict", 32'(res_valid), 32'd0);

        // R10/R11: wake flags
        wr(3'd5, 32'h82);
        send(BCAST, '0);
        @(negedge clk);
        chk("R10", "wake after broadcast", 32'(wake_flags), 32'h42);
        wr(3'd6, 32'h02);
        @(negedge clk);
        chk("R11", "wake after clear", 32'(wake_flags), 32'h40);
        send(BCAST, 7'h42);
        chk("R11", "set beats clear", 32'(wake_flags), 32'h42);
        wr(3'd6, 32'h7F);
        @(negedge clk);
        chk("R11", "wake cleared", 32'(wake_flags), 32'h00);
        wr(3'd5, 32'h01);
        send(UNI, '0);
        @(negedge clk);
        chk("R10", "no wake when disabled", 32'(wake_flags), 32'h00);

        // randomised frames against the model
        for (int n = 0; n < 80; n++) begin
            logic [47:0] a;
            int sel;
            sel = $urandom_range(0, 7);
            a = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            if (sel == 0) a = BCAST;
            if (n % 10 == 0) begin
                wr(3'd5, $urandom & 32'hBF | ((sel == 1) ? 32'h40 : 0));
                wr(3'd3, $urandom); wr(3'd4, $urandom);
            end
            if (sel == 2) set_station(a);
            send(a, (sel == 3) ? 7'($urandom) : 7'h0);
            if (sel == 4) wr(3'd6, $urandom);
        end

        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule